// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog for a system that must be pulled out of a hang without software help. Software programs a mode register with an enable bit, a reset-enable bit and a 4-bit interval code. It then keeps the timer alive through keyed writes to a control register. A write to the control register reloads the countdown only if it carries both the restart bit and a 12-bit key. Any other write to that register is discarded, so a stray store from runaway code cannot keep the dog fed.

Time is counted in half-second ticks, produced by a prescaler that divides the system clock by `TICK_DIV`. That parameter is set small for simulation. The interval code picks the timeout from a non-linear table. On expiry the countdown stops and a sticky timeout flag drives the interrupt output. If reset-enable is set, the block also drives a system reset pulse of `RST_CYCLES` clocks. Software clears the flag by writing 1 to it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the mode register reads 0, the status register reads 0, and `irq_o` and `sys_rst_o` are low.
- R2: The mode register at byte offset 0x4 holds enable in bit 0, reset-enable in bit 1 and the interval code in bits 6:3. It reads back those bits, with all other bits 0. Read data appears on `bus_rdata_o` one cycle after the read strobe.
- R3: A write to the control register at offset 0x0 reloads the full interval only when bit 0 is 1 and bits 12:1 equal 0xA57. The timeout is then due `N*TICK_DIV` clock edges after that write's edge. The control register reads as 0.
- R4: A control write with a wrong key, or with bit 0 clear, has no effect on the countdown.
- R5: Interval code c gives N half-second ticks: code 0 gives 1, code 1 gives 2, codes 2 to 6 give 2c (2 to 6 s), codes 7 to 11 give 16, 20, 24, 28 and 32 (8 to 16 s), and codes 12 to 15 give 32.
- R6: A mode write does not reload the count while enable stays set. While enable is clear, the counter holds and never expires. Setting enable from 0 starts a fresh full interval from the following edge.
- R7: Expiry sets a sticky flag, bit 0 of the status register at offset 0x8, which drives `irq_o`. Writing 1 to that bit clears it. After expiry the countdown stops until a keyed restart or a re-enable.
- R8: On expiry with reset-enable set, `sys_rst_o` is high for exactly `RST_CYCLES` cycles starting at the expiry edge. With reset-enable clear, it stays low.
- R9: A keyed restart after expiry starts a new full interval that expires again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Timeout interrupt (sticky flag) |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Read data is due one edge after the read strobe. The timeout flag and the start of the reset pulse are due exactly `N*TICK_DIV` edges after the edge that takes a keyed restart. After a 0-to-1 enable write, they are due one edge later than that. The bench samples at the falling edge and checks each output twice: on the last edge before a result is due, where it must still be inactive, and on the edge where it is due. A one-cycle slip in either direction therefore fails a check. The reset pulse is checked at its first and last high cycles and at the cycle after.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned KEY_W      = 12;
   localparam int unsigned KEY_LSB    = 1;
   localparam int unsigned RESTART_BIT = 0;
   localparam logic [KEY_W-1:0] RESTART_KEY = 12'hA57;
   localparam int unsigned EN_BIT     = 0;
   localparam int unsigned RSTEN_BIT  = 1;
   localparam int unsigned CODE_LSB   = 3;
   localparam int unsigned CODE_W     = 4;
   localparam int unsigned HALF_W     = 6;   // up to 32 half-second ticks

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              rst_en;
      logic              en;
   } mode_t;
endpackage

// File: rtl/kwd_interval.sv
module kwd_interval
   import kwd_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output logic [HALF_W-1:0] half_o
);
   // Code to number of half-second ticks; non-linear above code 6.
   always_comb begin
      if (code_i == '0)
         half_o = HALF_W'(1);
      else if (code_i <= CODE_W'(6))
         half_o = HALF_W'({code_i, 1'b0});
      else if (code_i <= CODE_W'(11))
         half_o = HALF_W'({code_i, 2'b00}) - HALF_W'(12);
      else
         half_o = HALF_W'(32);
   end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
   parameter int unsigned TICK_DIV = 12_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic clear_i,
   output logic tick_o
);
   initial assert (TICK_DIV >= 1) else $error("kwd_prescale: TICK_DIV must be at least 1");

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;

         assign tick_o = run_i && (cnt_q == LAST);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               cnt_q <= '0;
            else if (clear_i)
               cnt_q <= '0;
            else if (run_i)
               cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
         end

         // R5: ticks are TICK_DIV cycles apart, never back to back
         p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_o && !clear_i) |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/kwd_core.sv
module kwd_core
   import kwd_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              rst_en_i,
   input  logic [HALF_W-1:0] load_i,
   input  logic              restart_i,
   input  logic              tick_i,
   output logic              run_o,
   output logic              clear_o,
   output logic              expire_o,
   output logic              sys_rst_o
);
   localparam int unsigned PW = $clog2(RST_CYCLES + 1);

   initial assert (RST_CYCLES >= 1) else $error("kwd_core: RST_CYCLES must be at least 1");

   logic              en_prev_q;
   logic              expired_q;
   logic [HALF_W-1:0] remain_q;
   logic [PW-1:0]     pulse_q;
   logic              en_rise;
   logic              reload;

   assign en_rise  = en_i && !en_prev_q;
   assign reload   = restart_i || en_rise;
   assign run_o    = en_i && !expired_q;
   assign clear_o  = reload || !en_i;
   assign expire_o = run_o && tick_i && !reload && (remain_q == HALF_W'(1));
   assign sys_rst_o = (pulse_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_prev_q <= 1'b0;
         expired_q <= 1'b0;
         remain_q  <= HALF_W'(1);
      end else begin
         en_prev_q <= en_i;
         if (!en_i || reload) begin
            remain_q  <= load_i;
            expired_q <= 1'b0;
         end else if (expire_o) begin
            expired_q <= 1'b1;
         end else if (run_o && tick_i) begin
            remain_q <= remain_q - HALF_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pulse_q <= '0;
      else if (expire_o && rst_en_i)
         pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)
         pulse_q <= pulse_q - PW'(1);
   end

   // R8: a reset pulse only ever starts when reset-enable was set
   p_rst_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sys_rst_o) |-> $past(rst_en_i));

   // R7: once expired, the count is frozen until restart or disable
   p_stop_after_expiry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expired_q && en_i && !restart_i) |=> $stable(remain_q));

   // R5: each tick while running removes one half-second
   p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_o && tick_i && !reload && remain_q > HALF_W'(1))
      |=> remain_q == $past(remain_q) - HALF_W'(1));
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CTRL_OFS = 0,
   parameter int unsigned MODE_OFS = 4,
   parameter int unsigned STAT_OFS = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              expire_i,
   output logic [DATA_W-1:0] rdata_o,
   output mode_t             mode_o,
   output logic              restart_o,
   output logic              flag_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

   initial assert (CTRL_OFS != MODE_OFS && CTRL_OFS != STAT_OFS && MODE_OFS != STAT_OFS)
      else $error("kwd_regs: register offsets must differ");
   initial assert (KEY_LSB + KEY_W <= DATA_W) else $error("kwd_regs: key field exceeds data width");

   mode_t             mode_q;
   logic              flag_q;
   logic [DATA_W-1:0] rdata_q;
   logic              wr_ctrl, wr_mode, wr_stat;
   logic              unused_wbits;

   assign wr_ctrl = wr_i && (addr_i == A_CTRL);
   assign wr_mode = wr_i && (addr_i == A_MODE);
   assign wr_stat = wr_i && (addr_i == A_STAT);
   assign unused_wbits = ^wdata_i[DATA_W-1:KEY_LSB+KEY_W];

   assign restart_o = wr_ctrl && wdata_i[RESTART_BIT]
                      && (wdata_i[KEY_LSB +: KEY_W] == RESTART_KEY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= '0;
      end else if (wr_mode) begin
         mode_q.en     <= wdata_i[EN_BIT];
         mode_q.rst_en <= wdata_i[RSTEN_BIT];
         mode_q.code   <= wdata_i[CODE_LSB +: CODE_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         flag_q <= 1'b0;
      else if (expire_i)
         flag_q <= 1'b1;
      else if (wr_stat && wdata_i[0])
         flag_q <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
      end else if (rd_i) begin
         rdata_q <= '0;
         if (addr_i == A_MODE) begin
            rdata_q[EN_BIT]              <= mode_q.en;
            rdata_q[RSTEN_BIT]           <= mode_q.rst_en;
            rdata_q[CODE_LSB +: CODE_W]  <= mode_q.code;
         end else if (addr_i == A_STAT) begin
            rdata_q[0] <= flag_q;
         end
      end else begin
         rdata_q <= '0;
      end
   end

   assign mode_o  = mode_q;
   assign flag_o  = flag_q;
   assign rdata_o = rdata_q;

   // R7: the flag only drops through a write of 1 to the status register
   p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !(wr_stat && wdata_i[0])) |=> flag_q);

   // R3: the control register never reads back data
   p_ctrl_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == A_CTRL) |=> rdata_o == '0);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned TICK_DIV   = 12_000_000,
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o,
   output logic              sys_rst_o
);
   initial assert (ADDR_W >= 4) else $error("keyed_wdog: ADDR_W must reach offset 0x8");

   mode_t             mode;
   logic              restart, expire, run, clear, tick;
   logic [HALF_W-1:0] load;

   kwd_regs #(
      .ADDR_W   (ADDR_W),
      .CTRL_OFS (0),
      .MODE_OFS (4),
      .STAT_OFS (8)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .expire_i  (expire),
      .rdata_o   (bus_rdata_o),
      .mode_o    (mode),
      .restart_o (restart),
      .flag_o    (irq_o)
   );

   kwd_interval u_interval (
      .code_i (mode.code),
      .half_o (load)
   );

   kwd_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .clear_i (clear),
      .tick_o  (tick)
   );

   kwd_core #(.RST_CYCLES(RST_CYCLES)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (mode.en),
      .rst_en_i  (mode.rst_en),
      .load_i    (load),
      .restart_i (restart),
      .tick_i    (tick),
      .run_o     (run),
      .clear_o   (clear),
      .expire_o  (expire),
      .sys_rst_o (sys_rst_o)
   );
endmodule

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
   localparam int unsigned DIV  = 3;
   localparam int unsigned RSTC = 16;
   localparam logic [3:0]  A_CTRL = 4'h0;
   localparam logic [3:0]  A_MODE = 4'h4;
   localparam logic [3:0]  A_STAT = 4'h8;
   localparam logic [31:0] KEYED  = 32'h0000_14AF;  // key 0xA57 in 12:1, restart bit 0
   // expected half-second ticks per interval code (R5)
   localparam int EXP_HALF [16] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32, 32, 32, 32, 32};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sys_rst;
   int          tests = 0, fails = 0;
   bit          done = 1'b0;
   logic [31:0] rd;

   always #4 clk = ~clk;  // 125 MHz

   keyed_wdog #(.ADDR_W(4), .TICK_DIV(DIV), .RST_CYCLES(RSTC)) dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .bus_wr_i (bus_wr), .bus_rd_i (bus_rd), .bus_addr_i (bus_addr),
      .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata),
      .irq_o (irq), .sys_rst_o (sys_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // caller is at a falling edge; returns at the falling edge after the write edge
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiesce();
      bus_write(A_MODE, 32'h0);
      bus_write(A_STAT, 32'h1);
   endtask

   initial begin
      #(8 * 150_000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 sys_rst", {31'b0, sys_rst}, 32'h0);
      bus_read(A_MODE, rd); chk("R1 mode", rd, 32'h0);
      bus_read(A_STAT, rd); chk("R1 status", rd, 32'h0);

      // R2 field layout and readback masking (enable left clear)
      bus_write(A_MODE, 32'hFFFF_FF7A);
      bus_read(A_MODE, rd); chk("R2 mode readback", rd, 32'h0000_007A);
      // R3 control reads zero
      bus_write(A_CTRL, KEYED);
      bus_read(A_CTRL, rd); chk("R3 ctrl reads zero", rd, 32'h0);
      quiesce();

      // R5 vector walk over every interval code, reset-enable clear (R8)
      for (int c = 0; c < 16; c++) begin
         int cyc;
         cyc = EXP_HALF[c] * DIV;
         bus_write(A_MODE, (32'(c) << 3) | 32'h1);
         bus_write(A_CTRL, KEYED);
         wait_n(cyc - 1);
         chk($sformatf("R5 code %0d before due", c), {31'b0, irq}, 32'h0);
         wait_n(1);
         chk($sformatf("R5 code %0d due", c), {31'b0, irq}, 32'h1);
         chk($sformatf("R8 code %0d no reset", c), {31'b0, sys_rst}, 32'h0);
         quiesce();
         chk($sformatf("R7 code %0d flag cleared", c), {31'b0, irq}, 32'h0);
      end

      // R4 wrong key and missing restart bit leave the count alone
      bus_write(A_MODE, 32'h0000_0011);           // code 2: 4 ticks = 12 cycles
      bus_write(A_CTRL, KEYED);                   // E0
      wait_n(5);
      bus_write(A_CTRL, 32'h0000_14AE);           // key right, restart bit 0
      bus_write(A_CTRL, 32'h0000_14AD);           // key 0xA56
      wait_n(4);
      chk("R4 ignored writes: before due", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R4 ignored writes: due at original time", {31'b0, irq}, 32'h1);
      quiesce();

      // R3 keyed restart in mid-count reloads the full interval
      bus_write(A_MODE, 32'h0000_0011);
      bus_write(A_CTRL, KEYED);                   // E0
      wait_n(5);
      bus_write(A_CTRL, KEYED);                   // E0+6
      wait_n(11);
      chk("R3 reload: before new due", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R3 reload: new due", {31'b0, irq}, 32'h1);
      quiesce();

      // R6 mode write while enabled does not reload
      bus_write(A_MODE, 32'h0000_0011);
      bus_write(A_CTRL, KEYED);                   // E0
      wait_n(4);
      bus_write(A_MODE, 32'h0000_0059);           // code 11, still enabled, E0+5
      wait_n(6);
      chk("R6 mode write no reload: before due", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R6 mode write no reload: due", {31'b0, irq}, 32'h1);
      quiesce();

      // R6 disabled counter never expires, even with keyed restart
      bus_write(A_CTRL, KEYED);
      wait_n(200);
      chk("R6 disabled holds", {31'b0, irq}, 32'h0);

      // R6 enable 0->1 starts a fresh interval one edge after the mode write
      bus_write(A_MODE, 32'h0000_0001);           // code 0: 1 tick
      wait_n(3);
      chk("R6 enable fresh: before due", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R6 enable fresh: due", {31'b0, irq}, 32'h1);
      bus_read(A_STAT, rd); chk("R7 status bit", rd, 32'h1);

      // R7 count stopped after expiry: clearing the flag brings no new timeout
      bus_write(A_STAT, 32'h1);
      wait_n(100);
      chk("R7 stopped after expiry", {31'b0, irq}, 32'h0);

      // R9 keyed restart after expiry runs a new interval
      bus_write(A_CTRL, KEYED);
      wait_n(2);
      chk("R9 re-arm: before due", {31'b0, irq}, 32'h0);
      wait_n(1);
      chk("R9 re-arm: due", {31'b0, irq}, 32'h1);
      quiesce();

      // R8 reset pulse length with reset-enable set
      bus_write(A_MODE, 32'h0000_0003);
      bus_write(A_CTRL, KEYED);                   // E0
      wait_n(2);
      chk("R8 reset before expiry", {31'b0, sys_rst}, 32'h0);
      wait_n(1);
      chk("R8 reset first cycle", {31'b0, sys_rst}, 32'h1);
      wait_n(RSTC - 1);
      chk("R8 reset last cycle", {31'b0, sys_rst}, 32'h1);
      wait_n(1);
      chk("R8 reset ends", {31'b0, sys_rst}, 32'h0);
      quiesce();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule